// File: doc/BRIEF.md
# Five-Level CPU Interrupt Controller

This block sits beside a small 8-bit processor core and decides which of five interrupt request lines the core services next. One line is non-maskable. Three vectored lines (levels 5.5, 6.5 and 7.5) each carry their own mask bit. One general line takes its vector from outside the block. The core sets and clears a global interrupt-enable flag with enable and disable commands. It writes the mask bits with a set-mask command and reads the mask, enable and pending state back with a read-mask command.

The block raises `int_req` whenever some line is eligible. At an instruction boundary the core pulses `int_take`. On the next cycle the block returns the winning vector on `ack_vec` with a one-cycle `ack_vld`. At the same time it clears the global enable, so handlers do not nest unless software enables interrupts again. A request that is masked or disabled is not lost. Level lines keep requesting, and the edge-captured lines stay latched until they are serviced or cleared.

Top module: `irqc_top`

## Requirements
- R1: After synchronous reset the global enable is 0, all three mask bits are 1 (masked), both edge latches are empty, and `int_req` is low.
- R2: `cmd_di` clears the global enable and `cmd_ei` sets it. If both are given in the same cycle, the disable wins. While the enable is clear, only the non-maskable line can raise `int_req`.
- R3: `cmd_set_mask` loads the masks from `cmd_data[2:0]` (bit 0 = level 5.5, bit 1 = level 6.5, bit 2 = level 7.5, 1 = masked) only when `cmd_data[3]` is 1. Otherwise the masks are left unchanged.
- R4: `cmd_set_mask` with `cmd_data[4]` = 1 empties the level 7.5 latch, whatever `cmd_data[3]` is.
- R5: Priority is fixed, from highest to lowest: non-maskable, level 7.5, level 6.5, level 5.5, general.
- R6: The vectors are fixed: 0x0024 for non-maskable, 0x003C for level 7.5, 0x0034 for level 6.5, and 0x002C for level 5.5.
- R7: An accepted take clears the global enable. This also holds when `cmd_ei` comes in the same cycle.
- R8: The non-maskable line is captured on a rising edge. It raises `int_req` whatever the enable and mask bits are, and its latch empties when it is acknowledged.
- R9: Level 7.5 is captured on a rising edge and held. Levels 6.5, 5.5 and the general line are level-sensitive. A request that is masked or disabled stays pending and is serviced once it is allowed again.
- R10: One cycle after `cmd_read_mask`, `mask_rd` holds {0, pend7.5, pend6.5, pend5.5, enable, mask7.5, mask6.5, mask5.5}, from bit 7 down to bit 0.
- R11: When the general line wins, `ack_vec` equals `ext_vec` and `gen_ack` pulses together with `ack_vld`.
- R12: `ack_vld` pulses exactly one cycle after a cycle with `int_take` and `int_req` both high. A take while `int_req` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_nmi | input | 1 | Non-maskable request, rising-edge captured |
| irq_l75 | input | 1 | Level 7.5 request, rising-edge captured |
| irq_l65 | input | 1 | Level 6.5 request, level-sensitive |
| irq_l55 | input | 1 | Level 5.5 request, level-sensitive |
| irq_gen | input | 1 | General request, level-sensitive |
| ext_vec | input | 16 | Vector supplied for the general line |
| cmd_ei | input | 1 | Enable-interrupts command |
| cmd_di | input | 1 | Disable-interrupts command |
| cmd_set_mask | input | 1 | Set-mask command, data on cmd_data |
| cmd_read_mask | input | 1 | Read-mask command |
| cmd_data | input | 8 | Set-mask data word |
| int_take | input | 1 | Core accepts the offered interrupt |
| int_req | output | 1 | An eligible request is present |
| ack_vld | output | 1 | One-cycle acknowledge of an accepted interrupt |
| ack_vec | output | 16 | Vector of the accepted interrupt |
| gen_ack | output | 1 | Acknowledge for the general line |
| mask_rd | output | 8 | Read-mask result word |

## Verification
Acceptance and a software enable can fall in the same cycle, and so can acceptance and a rising edge on a line that is blocked. The bench provokes the first by driving `int_take` and `cmd_ei` in one cycle. It judges the result by whether `int_req` stays low afterwards while a level line is still held high. The second is provoked by pulsing the non-maskable and level 7.5 lines together. The bench then expects the non-maskable vector first, and the level 7.5 vector only after a fresh enable, which shows that the losing latch survived the acknowledge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int VEC_W   = 16;
    localparam int NSRC    = 5;
    localparam int NMASK   = 3;
    localparam int WORD_W  = 8;

    // source index = priority rank, higher index wins
    localparam int IDX_GEN = 0;
    localparam int IDX_L55 = 1;
    localparam int IDX_L65 = 2;
    localparam int IDX_L75 = 3;
    localparam int IDX_NMI = 4;

    // set-mask word fields
    localparam int SM_LOAD_BIT  = 3;
    localparam int SM_CLR75_BIT = 4;

    localparam logic [VEC_W-1:0] VEC_NMI = 16'h0024;
    localparam logic [VEC_W-1:0] VEC_L55 = 16'h002C;
    localparam logic [VEC_W-1:0] VEC_L65 = 16'h0034;
    localparam logic [VEC_W-1:0] VEC_L75 = 16'h003C;

    typedef struct packed {
        logic             ie;
        logic [NMASK-1:0] mask;   // [2]=7.5 [1]=6.5 [0]=5.5
    } ctrl_t;

    typedef struct packed {
        logic             vld;
        logic             gen;
        logic [VEC_W-1:0] vec;
    } ack_t;

    // keep only the highest set bit
    function automatic logic [NSRC-1:0] pick_top(input logic [NSRC-1:0] elig);
        logic [NSRC-1:0] g;
        logic            taken;
        g     = '0;
        taken = 1'b0;
        for (int i = NSRC-1; i >= 0; i--) begin
            if (elig[i] && !taken) begin
                g[i]  = 1'b1;
                taken = 1'b1;
            end
        end
        return g;
    endfunction

    function automatic logic [VEC_W-1:0] grant_vec(input logic [NSRC-1:0] g,
                                                   input logic [VEC_W-1:0] ext);
        logic [VEC_W-1:0] v;
        v = '0;
        if (g[IDX_NMI])      v = VEC_NMI;
        else if (g[IDX_L75]) v = VEC_L75;
        else if (g[IDX_L65]) v = VEC_L65;
        else if (g[IDX_L55]) v = VEC_L55;
        else if (g[IDX_GEN]) v = ext;
        return v;
    endfunction

endpackage

// File: rtl/irqc_edge_latch.sv
module irqc_edge_latch (
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  logic clr,
    output logic pend
);
    logic prev_q;
    logic pend_q;
    logic rise;

    assign rise = din & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= din;
            // a fresh edge outranks a clear in the same cycle
            if (rise)     pend_q <= 1'b1;
            else if (clr) pend_q <= 1'b0;
        end
    end

    assign pend = pend_q;
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
    import irqc_pkg::*;
(
    input  logic [NSRC-1:0] req,
    input  ctrl_t           ctrl,
    output logic [NSRC-1:0] grant,
    output logic            any
);
    logic [NSRC-1:0] elig;

    always_comb begin
        elig          = '0;
        elig[IDX_NMI] = req[IDX_NMI];
        elig[IDX_L75] = req[IDX_L75] & ctrl.ie & ~ctrl.mask[2];
        elig[IDX_L65] = req[IDX_L65] & ctrl.ie & ~ctrl.mask[1];
        elig[IDX_L55] = req[IDX_L55] & ctrl.ie & ~ctrl.mask[0];
        elig[IDX_GEN] = req[IDX_GEN] & ctrl.ie;
    end

    assign grant = pick_top(elig);
    assign any   = |elig;
endmodule

// File: rtl/irqc_ctrl_regs.sv
module irqc_ctrl_regs
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_ei,
    input  logic              cmd_di,
    input  logic              accept,
    input  logic              sm_wr,
    input  logic [WORD_W-1:0] sm_data,
    input  logic              rd_cmd,
    input  logic [NMASK-1:0]  pend3,
    output ctrl_t             ctrl,
    output logic [WORD_W-1:0] rd_word
);
    ctrl_t             ctrl_q;
    logic [WORD_W-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q.ie   <= 1'b0;
            ctrl_q.mask <= '1;
            rd_q        <= '0;
        end else begin
            if (accept || cmd_di) ctrl_q.ie <= 1'b0;
            else if (cmd_ei)      ctrl_q.ie <= 1'b1;

            if (sm_wr && sm_data[SM_LOAD_BIT])
                ctrl_q.mask <= sm_data[NMASK-1:0];

            if (rd_cmd)
                rd_q <= {1'b0, pend3, ctrl_q.ie, ctrl_q.mask};
        end
    end

    assign ctrl    = ctrl_q;
    assign rd_word = rd_q;
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              irq_nmi,
    input  logic              irq_l75,
    input  logic              irq_l65,
    input  logic              irq_l55,
    input  logic              irq_gen,
    input  logic [VEC_W-1:0]  ext_vec,
    input  logic              cmd_ei,
    input  logic              cmd_di,
    input  logic              cmd_set_mask,
    input  logic              cmd_read_mask,
    input  logic [WORD_W-1:0] cmd_data,
    input  logic              int_take,
    output logic              int_req,
    output logic              ack_vld,
    output logic [VEC_W-1:0]  ack_vec,
    output logic              gen_ack,
    output logic [WORD_W-1:0] mask_rd
);
    localparam int NEDGE = 2;   // 0: non-maskable, 1: level 7.5

    logic [NEDGE-1:0] edge_in;
    logic [NEDGE-1:0] edge_clr;
    logic [NEDGE-1:0] edge_pend;
    logic [NSRC-1:0]  req;
    logic [NSRC-1:0]  grant;
    logic             any;
    logic             accept;
    ctrl_t            ctrl;
    ack_t             ack_q;
    logic             nmi_pend;
    logic             ie;
    logic [NMASK-1:0] mask;

    assign accept = int_take & any;

    assign edge_in[0]  = irq_nmi;
    assign edge_in[1]  = irq_l75;
    assign edge_clr[0] = accept & grant[IDX_NMI];
    assign edge_clr[1] = (accept & grant[IDX_L75]) |
                         (cmd_set_mask & cmd_data[SM_CLR75_BIT]);

    for (genvar e = 0; e < NEDGE; e++) begin : g_edge
        irqc_edge_latch u_lat (
            .clk  (clk),
            .rst  (rst),
            .din  (edge_in[e]),
            .clr  (edge_clr[e]),
            .pend (edge_pend[e])
        );
    end

    always_comb begin
        req          = '0;
        req[IDX_NMI] = edge_pend[0];
        req[IDX_L75] = edge_pend[1];
        req[IDX_L65] = irq_l65;
        req[IDX_L55] = irq_l55;
        req[IDX_GEN] = irq_gen;
    end

    irqc_arbiter u_arb (
        .req   (req),
        .ctrl  (ctrl),
        .grant (grant),
        .any   (any)
    );

    irqc_ctrl_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .cmd_ei  (cmd_ei),
        .cmd_di  (cmd_di),
        .accept  (accept),
        .sm_wr   (cmd_set_mask),
        .sm_data (cmd_data),
        .rd_cmd  (cmd_read_mask),
        .pend3   ({edge_pend[1], irq_l65, irq_l55}),
        .ctrl    (ctrl),
        .rd_word (mask_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q <= '0;
        end else begin
            ack_q.vld <= accept;
            ack_q.gen <= accept & grant[IDX_GEN];
            if (accept) ack_q.vec <= grant_vec(grant, ext_vec);
        end
    end

    assign int_req  = any;
    assign ack_vld  = ack_q.vld;
    assign ack_vec  = ack_q.vec;
    assign gen_ack  = ack_q.gen;
    assign nmi_pend = edge_pend[0];
    assign ie       = ctrl.ie;
    assign mask     = ctrl.mask;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
    import irqc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              int_take,
    input logic              int_req,
    input logic              ack_vld,
    input logic [VEC_W-1:0]  ack_vec,
    input logic              gen_ack,
    input logic              cmd_ei,
    input logic              cmd_di,
    input logic              cmd_set_mask,
    input logic [WORD_W-1:0] cmd_data,
    input logic              ie,
    input logic [NMASK-1:0]  mask,
    input logic              nmi_pend,
    input logic [NSRC-1:0]   grant
);
    assert_accept_clears_ie_R7: assert property (@(posedge clk) disable iff (rst)
        (int_take && int_req) |=> !ie);

    assert_di_clears_R2: assert property (@(posedge clk) disable iff (rst)
        cmd_di |=> !ie);

    assert_ei_sets_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_ei && !cmd_di && !(int_take && int_req)) |=> ie);

    assert_ack_after_take_R12: assert property (@(posedge clk) disable iff (rst)
        (int_take && int_req) |=> ack_vld);

    assert_no_spurious_ack_R12: assert property (@(posedge clk) disable iff (rst)
        !(int_take && int_req) |=> !ack_vld);

    assert_nmi_always_offered_R8: assert property (@(posedge clk) disable iff (rst)
        nmi_pend |-> int_req);

    assert_single_winner_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    assert_gen_ack_with_ack_R11: assert property (@(posedge clk) disable iff (rst)
        gen_ack |-> ack_vld);

    assert_fixed_vectors_R6: assert property (@(posedge clk) disable iff (rst)
        (ack_vld && !gen_ack) |-> (ack_vec == VEC_NMI || ack_vec == VEC_L75 ||
                                   ack_vec == VEC_L65 || ack_vec == VEC_L55));

    assert_mask_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_set_mask && !cmd_data[SM_LOAD_BIT]) |=> $stable(mask));
endmodule

bind irqc_top irqc_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .int_take     (int_take),
    .int_req      (int_req),
    .ack_vld      (ack_vld),
    .ack_vec      (ack_vec),
    .gen_ack      (gen_ack),
    .cmd_ei       (cmd_ei),
    .cmd_di       (cmd_di),
    .cmd_set_mask (cmd_set_mask),
    .cmd_data     (cmd_data),
    .ie           (ie),
    .mask         (mask),
    .nmi_pend     (nmi_pend),
    .grant        (grant)
);

// File: tb/irqc_top_tb_top.sv
module irqc_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        irq_nmi = 0, irq_l75 = 0, irq_l65 = 0, irq_l55 = 0, irq_gen = 0;
    logic [15:0] ext_vec = 16'h0000;
    logic        cmd_ei = 0, cmd_di = 0, cmd_set_mask = 0, cmd_read_mask = 0;
    logic [7:0]  cmd_data = 8'h00;
    logic        int_take = 0;
    logic        int_req, ack_vld, gen_ack;
    logic [15:0] ack_vec;
    logic [7:0]  mask_rd;

    int total = 0;
    int bad   = 0;
    logic [16:0] expq [$];   // {gen, vec}

    always #5 clk = ~clk;

    irqc_top dut_i (
        .clk(clk), .rst(rst),
        .irq_nmi(irq_nmi), .irq_l75(irq_l75), .irq_l65(irq_l65),
        .irq_l55(irq_l55), .irq_gen(irq_gen), .ext_vec(ext_vec),
        .cmd_ei(cmd_ei), .cmd_di(cmd_di), .cmd_set_mask(cmd_set_mask),
        .cmd_read_mask(cmd_read_mask), .cmd_data(cmd_data),
        .int_take(int_take), .int_req(int_req), .ack_vld(ack_vld),
        .ack_vec(ack_vec), .gen_ack(gen_ack), .mask_rd(mask_rd)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic do_ei();
        cmd_ei = 1; cyc(); cmd_ei = 0;
    endtask

    task automatic do_di();
        cmd_di = 1; cyc(); cmd_di = 0;
    endtask

    task automatic set_mask(input logic [7:0] w);
        cmd_set_mask = 1; cmd_data = w; cyc(); cmd_set_mask = 0; cmd_data = 8'h00;
    endtask

    task automatic read_mask(input string req, input logic [7:0] exp);
        cmd_read_mask = 1; cyc(); cmd_read_mask = 0;
        chk(req, mask_rd, exp);
    endtask

    task automatic pulse_edge(input logic nmi, input logic l75);
        irq_nmi = nmi; irq_l75 = l75; cyc(); irq_nmi = 0; irq_l75 = 0; cyc();
    endtask

    // driver: push expectation, then issue take
    task automatic take(input string req, input logic [15:0] vec, input logic gen,
                        input logic with_ei);
        chk(req, int_req, 1);
        expq.push_back({gen, vec});
        int_take = 1; cmd_ei = with_ei;
        cyc();
        int_take = 0; cmd_ei = 0;
    endtask

    // monitor: pop and compare acknowledges
    always @(negedge clk) begin
        if (!rst && ack_vld) begin
            if (expq.size() == 0) begin
                total++; bad++;
                $display("FAIL R12 actual=ack expected=no ack");
            end else begin
                logic [16:0] e;
                e = expq.pop_front();
                chk("R6 vector", ack_vec, e[15:0]);
                chk("R11 gen_ack", gen_ack, e[16]);
            end
        end
    end

    initial begin
        #150000;
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) cyc();
        rst = 0;
        cyc();
        // R1 reset state
        chk("R1 int_req", int_req, 0);
        read_mask("R1 R10 reset word", 8'h07);

        // R8 NMI with enable clear and all masked
        pulse_edge(1, 0);
        chk("R8 nmi offered", int_req, 1);
        take("R8", 16'h0024, 0, 0);
        chk("R8 latch emptied", int_req, 0);

        // R3 mask load qualifier
        set_mask(8'h08);
        read_mask("R3 load", 8'h00);
        set_mask(8'h07);
        read_mask("R3 no load", 8'h00);
        do_ei();
        read_mask("R2 R10 ei", 8'h08);

        // R9 level line retained across acceptance
        irq_l55 = 1; cyc();
        take("R9 l55", 16'h002C, 0, 0);
        chk("R7 ie cleared", int_req, 0);
        read_mask("R9 R10 pending 5.5", 8'h10);
        do_ei();
        take("R9 l55 again", 16'h002C, 0, 0);

        // R5 priority among level lines
        do_ei();
        irq_l65 = 1; irq_gen = 1; cyc();
        take("R5 6.5 first", 16'h0034, 0, 0);
        irq_l65 = 0; do_ei();
        take("R5 5.5 next", 16'h002C, 0, 0);
        irq_l55 = 0; ext_vec = 16'h1234; do_ei();
        take("R11 general", 16'h1234, 1, 0);
        irq_gen = 0; cyc();

        // R2 disable blocks, NMI still passes
        do_ei();
        irq_l65 = 1; cyc();
        chk("R2 enabled", int_req, 1);
        do_di();
        chk("R2 disabled", int_req, 0);
        pulse_edge(1, 0);
        take("R8 under di", 16'h0024, 0, 0);
        chk("R8 after", int_req, 0);
        irq_l65 = 0;

        // R9 masked 7.5 stays latched
        set_mask(8'h0C);
        do_ei();
        pulse_edge(0, 1);
        chk("R9 masked 7.5", int_req, 0);
        read_mask("R9 R10 pend 7.5", 8'h4C);
        set_mask(8'h08);
        take("R9 7.5", 16'h003C, 0, 0);
        read_mask("R9 7.5 emptied", 8'h00);

        // R4 clear 7.5 latch via set-mask bit 4
        set_mask(8'h0C);
        pulse_edge(0, 1);
        set_mask(8'h14);
        read_mask("R4 cleared, R3 kept", 8'h04);
        do_ei(); set_mask(8'h08);
        chk("R4 no request", int_req, 0);

        // R5 NMI outranks 7.5 in the same cycle
        pulse_edge(1, 1);
        take("R5 nmi first", 16'h0024, 0, 0);
        chk("R7 blocked after take", int_req, 0);
        do_ei();
        take("R5 7.5 survives", 16'h003C, 0, 0);

        // R7 take and ei in the same cycle
        do_ei();
        irq_l55 = 1; cyc();
        take("R7 with ei", 16'h002C, 0, 1);
        chk("R7 take wins", int_req, 0);
        irq_l55 = 0; cyc();

        // R2 di and ei together
        cmd_ei = 1; cmd_di = 1; cyc(); cmd_ei = 0; cmd_di = 0;
        read_mask("R2 di wins", 8'h00);

        // R12 take without request is ignored
        int_take = 1; cyc(); int_take = 0;
        chk("R12 no ack", ack_vld, 0);
        cyc();
        chk("R12 queue drained", expq.size(), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule